// File: doc/BRIEF.md
# 1-Wire Slave Time-Slot Responder

This block is the physical layer of a 1-Wire slave. It watches the sampled bus line, passes it through a synchronizer, and drives an open-drain pull-down. Every bus event is timed in clock cycles derived from a clocks-per-microsecond parameter. The overdrive input picks between two timing sets, standard and overdrive.

The block handles four kinds of bus activity:

- **Reset.** A long low on the line is taken as a reset. The block flags it with a one-cycle pulse. It then waits out the presence-high delay and drives the presence pulse.
- **Master slot start.** Any shorter falling edge from the master opens a slot.
- **Write slot.** The line level is sampled at a fixed delay after the falling edge. The bit is handed to the upper layer once the line has returned high.
- **Read slot.** The upper layer chooses a read slot by raising the transmit request before the slot starts. The slave then holds the line low for a 0 or leaves it alone for a 1.

Command decoding, address matching and storage belong to the layers above.

Top module: `ow_slot_responder`

## Requirements
- R1: After reset, bus_pull, rx_valid and reset_seen are all 0.
- R2: A continuous low lasting at least the reset threshold (480 µs standard, 48 µs overdrive) gives exactly one one-cycle reset_seen pulse, a few cycles after the threshold is crossed. A low shorter than the threshold by a few µs gives no pulse.
- R3: After the line rises at the end of a reset, bus_pull goes to 1 about 30 µs later (3 µs in overdrive), to within a few cycles. It stays at 1 for 120 µs (10 µs in overdrive) and then returns to 0.
- R4: In a write slot (tx_req = 0 at the falling edge), the line is sampled 30 µs (standard) or 3 µs (overdrive) after the falling edge. A high line gives bit 1 and a low line gives bit 0.
- R5: Each completed write slot gives exactly one one-cycle rx_valid pulse, a few cycles after the line is high again. rx_bit holds the sampled bit during that pulse.
- R6: A low period that reaches the reset threshold aborts the slot in progress, so no rx_valid pulse is issued for it.
- R7: In a read slot with tx_bit = 0 (tx_req = 1 at the falling edge), bus_pull is 1 from just after the falling edge until 45 µs (standard) or 5 µs (overdrive) after it, and 0 afterwards.
- R8: In a read slot with tx_bit = 1, bus_pull stays 0. Read slots of either value never produce an rx_valid pulse.
- R9: Outside the presence pulse, bus_pull only goes to 1 while the line is already low. With the line idle high, the block never pulls it low.
- R10: With overdrive = 1, every threshold switches to its overdrive value. With overdrive = 0, the standard values apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Raw level of the 1-Wire line (1 = high) |
| overdrive | input | 1 | 1 selects the overdrive timing set |
| tx_req | input | 1 | 1 at the start of a slot makes it a read slot |
| tx_bit | input | 1 | Bit sent in a read slot |
| bus_pull | output | 1 | 1 turns on the open-drain pull-down |
| rx_valid | output | 1 | One-cycle strobe for a received write bit |
| rx_bit | output | 1 | Received write bit, valid with rx_valid |
| reset_seen | output | 1 | One-cycle pulse on reset detection |

## Verification
The embedded assertions check every cycle that:

- bus_pull only turns on while the line is already low, or at the start of presence;
- bus_pull is never active outside a read slot or the presence pulse;
- rx_valid and reset_seen are single-cycle strobes;
- a reset never coincides with a bit strobe or an active pull-down.

Only the bench can show the timing against the actual bus: where the sample point sits, obtained by sweeping the master's low width in both modes; the read-0 hold window; the presence delay and width; and the behaviour just either side of the reset threshold.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLOT,
      ST_WAIT_HI,
      ST_RST_WAIT,
      ST_PD_WAIT,
      ST_PD_LOW,
      ST_PD_REL
   } ow_state_e;

   function automatic int us_to_cyc(input int us, input int clk_per_us);
      return us * clk_per_us;
   endfunction

endpackage

// File: rtl/ow_slot_timing.sv
module ow_slot_timing
   import ow_slot_pkg::*;
#(
   parameter int CLK_PER_US  = 16,
   parameter int CW          = 13,
   parameter bit OVD_EN      = 1'b1,
   parameter int STD_SAMP_US = 30,
   parameter int STD_REL_US  = 45,
   parameter int STD_RST_US  = 480,
   parameter int STD_PDH_US  = 30,
   parameter int STD_PDL_US  = 120,
   parameter int OVD_SAMP_US = 3,
   parameter int OVD_REL_US  = 5,
   parameter int OVD_RST_US  = 48,
   parameter int OVD_PDH_US  = 3,
   parameter int OVD_PDL_US  = 10
) (
   input  logic          overdrive,
   output logic [CW-1:0] t_samp,
   output logic [CW-1:0] t_rel,
   output logic [CW-1:0] t_rst,
   output logic [CW-1:0] t_pdh,
   output logic [CW-1:0] t_pdl
);

   localparam logic [CW-1:0] S_SAMP = CW'(us_to_cyc(STD_SAMP_US, CLK_PER_US));
   localparam logic [CW-1:0] S_REL  = CW'(us_to_cyc(STD_REL_US,  CLK_PER_US));
   localparam logic [CW-1:0] S_RST  = CW'(us_to_cyc(STD_RST_US,  CLK_PER_US));
   localparam logic [CW-1:0] S_PDH  = CW'(us_to_cyc(STD_PDH_US,  CLK_PER_US));
   localparam logic [CW-1:0] S_PDL  = CW'(us_to_cyc(STD_PDL_US,  CLK_PER_US));
   localparam logic [CW-1:0] O_SAMP = CW'(us_to_cyc(OVD_SAMP_US, CLK_PER_US));
   localparam logic [CW-1:0] O_REL  = CW'(us_to_cyc(OVD_REL_US,  CLK_PER_US));
   localparam logic [CW-1:0] O_RST  = CW'(us_to_cyc(OVD_RST_US,  CLK_PER_US));
   localparam logic [CW-1:0] O_PDH  = CW'(us_to_cyc(OVD_PDH_US,  CLK_PER_US));
   localparam logic [CW-1:0] O_PDL  = CW'(us_to_cyc(OVD_PDL_US,  CLK_PER_US));

   generate
      if (OVD_EN) begin : g_dual
         always_comb begin
            t_samp = overdrive ? O_SAMP : S_SAMP;
            t_rel  = overdrive ? O_REL  : S_REL;
            t_rst  = overdrive ? O_RST  : S_RST;
            t_pdh  = overdrive ? O_PDH  : S_PDH;
            t_pdl  = overdrive ? O_PDL  : S_PDL;
         end
      end else begin : g_std_only
         logic unused_ovd;
         assign unused_ovd = overdrive;
         always_comb begin
            t_samp = S_SAMP;
            t_rel  = S_REL;
            t_rst  = S_RST;
            t_pdh  = S_PDH;
            t_pdl  = S_PDL;
         end
      end
   endgenerate

endmodule

// File: rtl/ow_line_mon.sv
module ow_line_mon #(
   parameter int SYNC_STAGES = 2,
   parameter int CW          = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_in,
   input  logic [CW-1:0] t_rst,
   output logic          line_s,
   output logic          fall,
   output logic          rst_hit
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic [CW-1:0]          low_cnt;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b1;
               else        sync_q[gi] <= bus_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b1;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   assign line_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         low_cnt <= '0;
      end else begin
         prev_q <= line_s;
         if (line_s)
            low_cnt <= '0;
         else if (low_cnt != t_rst)
            low_cnt <= low_cnt + 1'b1;
      end
   end

   assign fall    = prev_q & ~line_s;
   assign rst_hit = ~line_s & (low_cnt == t_rst - 1'b1);

   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R4

   AST_RST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_hit |=> !rst_hit); // R2

endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
   import ow_slot_pkg::*;
#(
   parameter int CW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_s,
   input  logic          fall,
   input  logic          rst_hit,
   input  logic          tx_req,
   input  logic          tx_bit,
   input  logic [CW-1:0] t_samp,
   input  logic [CW-1:0] t_rel,
   input  logic [CW-1:0] t_pdh,
   input  logic [CW-1:0] t_pdl,
   output logic          bus_pull,
   output logic          rx_valid,
   output logic          rx_bit,
   output logic          reset_seen
);

   ow_state_e     st;
   logic [CW-1:0] cnt;
   logic          slot_rd;
   logic          samp_q;
   logic          abortable;

   assign abortable = (st == ST_IDLE) || (st == ST_SLOT) || (st == ST_WAIT_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         slot_rd    <= 1'b0;
         samp_q     <= 1'b0;
         bus_pull   <= 1'b0;
         rx_valid   <= 1'b0;
         rx_bit     <= 1'b0;
         reset_seen <= 1'b0;
      end else begin
         rx_valid   <= 1'b0;
         reset_seen <= 1'b0;
         if (rst_hit && abortable) begin
            st         <= ST_RST_WAIT;
            bus_pull   <= 1'b0;
            reset_seen <= 1'b1;
         end else begin
            case (st)
               ST_IDLE: begin
                  if (fall) begin
                     st       <= ST_SLOT;
                     cnt      <= '0;
                     slot_rd  <= tx_req;
                     bus_pull <= tx_req & ~tx_bit;
                  end
               end
               ST_SLOT: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == t_samp - 1'b1)
                     samp_q <= line_s;
                  if (cnt == t_rel - 1'b1) begin
                     bus_pull <= 1'b0;
                     st       <= ST_WAIT_HI;
                  end
               end
               ST_WAIT_HI: begin
                  if (line_s) begin
                     st <= ST_IDLE;
                     if (!slot_rd) begin
                        rx_valid <= 1'b1;
                        rx_bit   <= samp_q;
                     end
                  end
               end
               ST_RST_WAIT: begin
                  if (line_s) begin
                     st  <= ST_PD_WAIT;
                     cnt <= '0;
                  end
               end
               ST_PD_WAIT: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == t_pdh - 1'b1) begin
                     st       <= ST_PD_LOW;
                     bus_pull <= 1'b1;
                     cnt      <= '0;
                  end
               end
               ST_PD_LOW: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == t_pdl - 1'b1) begin
                     bus_pull <= 1'b0;
                     st       <= ST_PD_REL;
                  end
               end
               ST_PD_REL: begin
                  if (line_s)
                     st <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   AST_PULL_ON_LOW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_pull) && st != ST_PD_LOW) |-> !line_s); // R9

   AST_PULL_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_pull |-> (st == ST_SLOT || st == ST_PD_LOW)); // R7

   AST_WRITE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SLOT && !slot_rd) |-> !bus_pull); // R8

   AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R5

   AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reset_seen |=> !reset_seen); // R2

   AST_RST_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
      reset_seen |-> (!rx_valid && !bus_pull)); // R6

endmodule

// File: rtl/ow_slot_responder.sv
module ow_slot_responder #(
   parameter int CLK_PER_US  = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit OVD_EN      = 1'b1,
   parameter int STD_SAMP_US = 30,
   parameter int STD_REL_US  = 45,
   parameter int STD_RST_US  = 480,
   parameter int STD_PDH_US  = 30,
   parameter int STD_PDL_US  = 120,
   parameter int OVD_SAMP_US = 3,
   parameter int OVD_REL_US  = 5,
   parameter int OVD_RST_US  = 48,
   parameter int OVD_PDH_US  = 3,
   parameter int OVD_PDL_US  = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_in,
   input  logic overdrive,
   input  logic tx_req,
   input  logic tx_bit,
   output logic bus_pull,
   output logic rx_valid,
   output logic rx_bit,
   output logic reset_seen
);

   localparam int MAX_CYC = STD_RST_US * CLK_PER_US;
   localparam int CW      = $clog2(MAX_CYC + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CLK_PER_US < 2) begin : g_bad_clk
         $error("CLK_PER_US must be at least 2");
      end
      if (STD_SAMP_US >= STD_REL_US || OVD_SAMP_US >= OVD_REL_US) begin : g_bad_samp
         $error("sample point must precede read-0 release");
      end
      if (STD_REL_US >= STD_RST_US || OVD_REL_US >= OVD_RST_US) begin : g_bad_rel
         $error("read-0 release must precede reset threshold");
      end
      if (STD_PDL_US >= STD_RST_US || OVD_PDL_US >= OVD_RST_US) begin : g_bad_pdl
         $error("presence low must be shorter than reset threshold");
      end
      if (OVD_RST_US > STD_RST_US || OVD_PDH_US < 1 || STD_PDH_US < 1) begin : g_bad_misc
         $error("timing set out of range");
      end
   endgenerate

   logic [CW-1:0] t_samp, t_rel, t_rst, t_pdh, t_pdl;
   logic          line_s, fall, rst_hit;

   ow_slot_timing #(
      .CLK_PER_US (CLK_PER_US),  .CW (CW), .OVD_EN (OVD_EN),
      .STD_SAMP_US(STD_SAMP_US), .STD_REL_US(STD_REL_US), .STD_RST_US(STD_RST_US),
      .STD_PDH_US (STD_PDH_US),  .STD_PDL_US(STD_PDL_US),
      .OVD_SAMP_US(OVD_SAMP_US), .OVD_REL_US(OVD_REL_US), .OVD_RST_US(OVD_RST_US),
      .OVD_PDH_US (OVD_PDH_US),  .OVD_PDL_US(OVD_PDL_US)
   ) timing_i (
      .overdrive(overdrive),
      .t_samp   (t_samp),
      .t_rel    (t_rel),
      .t_rst    (t_rst),
      .t_pdh    (t_pdh),
      .t_pdl    (t_pdl)
   );

   ow_line_mon #(
      .SYNC_STAGES(SYNC_STAGES),
      .CW         (CW)
   ) mon_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .bus_in (bus_in),
      .t_rst  (t_rst),
      .line_s (line_s),
      .fall   (fall),
      .rst_hit(rst_hit)
   );

   ow_slot_fsm #(
      .CW(CW)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_s    (line_s),
      .fall      (fall),
      .rst_hit   (rst_hit),
      .tx_req    (tx_req),
      .tx_bit    (tx_bit),
      .t_samp    (t_samp),
      .t_rel     (t_rel),
      .t_pdh     (t_pdh),
      .t_pdl     (t_pdl),
      .bus_pull  (bus_pull),
      .rx_valid  (rx_valid),
      .rx_bit    (rx_bit),
      .reset_seen(reset_seen)
   );

endmodule

// File: tb/ow_slot_responder_tb.sv
module ow_slot_responder_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CPU        = 4;

   localparam int S_SAMP = 30 * CPU;
   localparam int S_REL  = 45 * CPU;
   localparam int S_RST  = 480 * CPU;
   localparam int S_PDH  = 30 * CPU;
   localparam int S_PDL  = 120 * CPU;
   localparam int O_SAMP = 3 * CPU;
   localparam int O_REL  = 5 * CPU;
   localparam int O_RST  = 48 * CPU;
   localparam int O_PDH  = 3 * CPU;
   localparam int O_PDL  = 10 * CPU;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_low = 1'b0;
   logic overdrive = 1'b0;
   logic tx_req = 1'b0;
   logic tx_bit = 1'b0;
   logic bus_pull, rx_valid, rx_bit, reset_seen;
   logic bus_in;

   int checks = 0;
   int failures = 0;
   int rx_cnt = 0;
   int rst_cnt = 0;
   logic rx_last = 1'b0;
   bit done = 1'b0;

   assign bus_in = ~(m_low | bus_pull);

   always #(CLK_PERIOD/2) clk = ~clk;

   ow_slot_responder #(.CLK_PER_US(CPU)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .overdrive(overdrive),
      .tx_req(tx_req), .tx_bit(tx_bit), .bus_pull(bus_pull),
      .rx_valid(rx_valid), .rx_bit(rx_bit), .reset_seen(reset_seen)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_cnt  = rx_cnt + 1;
         rx_last = rx_bit;
      end
      if (reset_seen) rst_cnt = rst_cnt + 1;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_slot(input int lc, input int rel, input bit exp, input string tag);
      int r0;
      r0 = rx_cnt;
      tx_req = 1'b0;
      m_low = 1'b1;
      cyc(lc);
      m_low = 1'b0;
      cyc(((lc > rel) ? 0 : rel - lc) + 16);
      chk(rx_cnt == r0 + 1, {tag, " R5 one strobe"}, rx_cnt - r0, 1);
      chk(rx_last == exp, {tag, " R4 bit"}, rx_last, exp);
   endtask

   task automatic read_slot(input bit b, input int rel, input string tag);
      int r0;
      r0 = rx_cnt;
      tx_req = 1'b1;
      tx_bit = b;
      m_low = 1'b1;
      cyc(8);
      m_low = 1'b0;
      cyc(rel - 10);
      if (b == 1'b0)
         chk(bus_in == 1'b0, {tag, " R7 held low"}, bus_in, 0);
      else
         chk(bus_in == 1'b1 && bus_pull == 1'b0, {tag, " R8 no hold"}, bus_pull, 0);
      cyc(8);
      chk(bus_in == 1'b1, {tag, " R7 released"}, bus_in, 1);
      cyc(16);
      chk(rx_cnt == r0, {tag, " R8 no strobe"}, rx_cnt - r0, 0);
      tx_req = 1'b0;
   endtask

   task automatic reset_seq(input int rst, input int pdh, input int pdl, input string tag);
      int s0, r0;
      s0 = rst_cnt;
      r0 = rx_cnt;
      m_low = 1'b1;
      cyc(rst - 4);
      chk(rst_cnt == s0, {tag, " R2 no early"}, rst_cnt - s0, 0);
      cyc(44);
      chk(rst_cnt == s0 + 1, {tag, " R2 one pulse"}, rst_cnt - s0, 1);
      m_low = 1'b0;
      cyc(pdh - 2);
      chk(bus_in == 1'b1, {tag, " R3 pre-presence high"}, bus_in, 1);
      cyc(10);
      chk(bus_pull == 1'b1, {tag, " R3 presence start"}, bus_pull, 1);
      cyc(pdl - 10);
      chk(bus_pull == 1'b1, {tag, " R3 presence held"}, bus_pull, 1);
      cyc(10);
      chk(bus_pull == 1'b0 && bus_in == 1'b1, {tag, " R3 presence end"}, bus_pull, 0);
      cyc(8);
      chk(rx_cnt == r0, {tag, " R6 aborted slot"}, rx_cnt - r0, 0);
   endtask

   task automatic short_low(input int rst, input int rel, input string tag);
      int s0;
      s0 = rst_cnt;
      write_slot(rst - 40, rel, 1'b0, tag);
      chk(rst_cnt == s0, {tag, " R2 below threshold"}, rst_cnt - s0, 0);
   endtask

   initial begin
      cyc(4);
      chk(bus_pull == 1'b0 && rx_valid == 1'b0 && reset_seen == 1'b0,
          "R1 reset state", {bus_pull, rx_valid, reset_seen}, 0);
      rst_n = 1'b1;
      cyc(4);
      chk(bus_pull == 1'b0, "R1 after release", bus_pull, 0);

      // R9: idle line with a pending read 0 is never pulled
      tx_req = 1'b1;
      tx_bit = 1'b0;
      cyc(200);
      chk(bus_in == 1'b1 && rst_cnt == 0 && rx_cnt == 0, "R9 idle untouched", bus_in, 1);
      tx_req = 1'b0;

      // Standard mode
      reset_seq(S_RST, S_PDH, S_PDL, "std");
      for (int lc = 4; lc <= 280; lc += 12) begin
         if (lc < S_SAMP - 3 || lc > S_SAMP + 4)
            write_slot(lc, S_REL, (lc < S_SAMP), "std sweep");
      end
      read_slot(1'b0, S_REL, "std rd0");
      read_slot(1'b1, S_REL, "std rd1");
      short_low(S_RST, S_REL, "std");

      // Overdrive mode R10
      overdrive = 1'b1;
      cyc(4);
      reset_seq(O_RST, O_PDH, O_PDL, "ovd R10");
      for (int lc = 2; lc <= 40; lc++) begin
         if (lc < O_SAMP - 3 || lc > O_SAMP + 4)
            write_slot(lc, O_REL, (lc < O_SAMP), "ovd R10 sweep");
      end
      read_slot(1'b0, O_REL, "ovd R10 rd0");
      read_slot(1'b1, O_REL, "ovd R10 rd1");
      short_low(O_RST, O_REL, "ovd R10");

      // back to standard: overdrive-length low is a normal slot
      overdrive = 1'b0;
      cyc(4);
      write_slot(O_RST + 40, S_REL, 1'b0, "R10 std threshold");
      chk(rst_cnt == 2, "R10 std ignores short reset", rst_cnt, 2);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule